// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor's word port and a line-wide memory port. Each address has three parts: a tag, a set index and an offset into the line. The set index picks one set of two lines. Both stored tags in that set are compared in the same cycle, and each comparison counts only if its line is valid. The two match signals are ORed to form the hit. The same two signals steer the multiplexer that returns the word from the matching way.

A read that hits returns its word in the cycle of the request. A write that hits updates the word in the matching way and marks that line dirty. On a miss the processor is held. The victim is an empty way if the set has one. Otherwise it is the way that one per-set recency bit marks as least recently used. If the victim is dirty, it is written back to memory first. Then the missing line is fetched, and the held request completes as a hit.

The processor must hold its request stable until `cpu_ready` is high. The memory side raises `mem_ack` for one cycle to finish each line transfer.

Top module: `sa2_cache`

## Requirements
- R1: The address is split as follows: bits [1:0] are the byte offset and are ignored, bits [3:2] select the word in the line, bits [6:4] select one of 8 sets, and bits [11:7] are the tag.
- R2: When a request hits, `cpu_ready` is high in the same cycle, `cpu_rdata` carries the addressed word, and no memory transfer is started.
- R3: On a miss, an invalid way is filled before a valid one, and way 0 is filled before way 1.
- R4: Each set keeps one recency bit, which is updated on every hit and every refill. When both ways are valid, a miss evicts the way that was accessed less recently.
- R5: A write hit replaces the addressed word. Later reads of that word return the new value, and the line becomes dirty.
- R6: A dirty victim is written to memory before the refill. The write-back uses the victim's own line address and carries its current data.
- R7: A clean or invalid victim is never written back. The miss performs only the refill.
- R8: During miss handling `cpu_ready` stays low. After the refill, the held request completes as a hit and returns the refilled or written data.
- R9: After reset no line is valid, so the first access to any set misses, and `cpu_ready` and `mem_req` are low.
- R10: At most one way of a set ever matches a given tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid when cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Line transfer in progress |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_line_addr | output | 8 | Line address (tag and set) |
| mem_wline | output | 128 | Write-back line data |
| mem_rline | input | 128 | Refill line data, taken when mem_ack |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
A wrong recency bit or a wrong valid bit shows up as a hit where a miss was expected, or the reverse. That difference appears at the very next access to the same set. It is seen as `cpu_ready` coming too early or too late. A dirty bit that is lost or set when it should not be shows up at the eviction of that line. The write-back is missing or extra, and the word read back later is stale. A stored tag or data word that is corrupted makes a read return a value different from the flat memory model. This happens on the first read of the affected word.

// File: rtl/sa2_cache.sv
module sa2_cache #(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cpu_req,
  input  logic                                   cpu_we,
  input  logic [ADDR_W-1:0]                      cpu_addr,
  input  logic [WORD_W-1:0]                      cpu_wdata,
  output logic [WORD_W-1:0]                      cpu_rdata,
  output logic                                   cpu_ready,
  output logic                                   mem_req,
  output logic                                   mem_we,
  output logic [ADDR_W-$clog2(WORD_W/8)-$clog2(LINE_WORDS)-1:0] mem_line_addr,
  output logic [WORD_W*LINE_WORDS-1:0]           mem_wline,
  input  logic [WORD_W*LINE_WORDS-1:0]           mem_rline,
  input  logic                                   mem_ack
);
  localparam int OFF_W   = $clog2(WORD_W/8);
  localparam int WSEL_W  = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = ADDR_W - OFF_W - WSEL_W - IDX_W;
  localparam int LINE_W  = WORD_W * LINE_WORDS;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} state_t;

  state_t            state_q;
  logic              vic_q;
  logic [TAG_W-1:0]  tag_q   [2][SETS];
  logic [LINE_W-1:0] data_q  [2][SETS];
  logic              valid_q [2][SETS];
  logic              dirty_q [2][SETS];
  logic              lru_q   [SETS];

  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  logic [TAG_W-1:0]  tag;
  logic              match0, match1, hit, hit_way, pick;
  logic [LINE_W-1:0] line_sel;

  assign idx  = cpu_addr[OFF_W+WSEL_W +: IDX_W];
  assign wsel = cpu_addr[OFF_W +: WSEL_W];
  assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];

  assign match0  = valid_q[0][idx] && (tag_q[0][idx] == tag);
  assign match1  = valid_q[1][idx] && (tag_q[1][idx] == tag);
  assign hit     = match0 | match1;
  assign hit_way = match1;
  assign line_sel  = match1 ? data_q[1][idx] : data_q[0][idx];
  assign cpu_rdata = line_sel[wsel*WORD_W +: WORD_W];

  assign pick = !valid_q[0][idx] ? 1'b0 :
                !valid_q[1][idx] ? 1'b1 : lru_q[idx];

  assign cpu_ready     = (state_q == S_IDLE) && cpu_req && hit;
  assign mem_req       = (state_q != S_IDLE);
  assign mem_we        = (state_q == S_WB);
  assign mem_line_addr = (state_q == S_WB) ? {tag_q[vic_q][idx], idx} : {tag, idx};
  assign mem_wline     = data_q[vic_q][idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      vic_q   <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        lru_q[s] <= 1'b0;
        for (int w = 0; w < 2; w++) begin
          valid_q[w][s] <= 1'b0;
          dirty_q[w][s] <= 1'b0;
        end
      end
    end else begin
      case (state_q)
        S_IDLE: if (cpu_req) begin
          if (hit) begin
            lru_q[idx] <= ~hit_way;
            if (cpu_we) dirty_q[hit_way][idx] <= 1'b1;
          end else begin
            vic_q   <= pick;
            state_q <= (valid_q[pick][idx] && dirty_q[pick][idx]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) state_q <= S_FILL;
        S_FILL: if (mem_ack) begin
          valid_q[vic_q][idx] <= 1'b1;
          dirty_q[vic_q][idx] <= 1'b0;
          lru_q[idx]          <= ~vic_q;
          state_q             <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_FILL && mem_ack) begin
      tag_q[vic_q][idx]  <= tag;
      data_q[vic_q][idx] <= mem_rline;
    end else if (state_q == S_IDLE && cpu_req && hit && cpu_we) begin
      data_q[hit_way][idx][wsel*WORD_W +: WORD_W] <= cpu_wdata;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !(match0 && match1)); // R10

  AST_LRU_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && cpu_req && hit) |=> (lru_q[$past(idx)] == $past(match0))); // R4

  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && cpu_req && cpu_we && match0) |=> dirty_q[0][$past(idx)]); // R5

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ack) |=> (mem_req && !mem_we)); // R6

  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && cpu_req && !hit && !(valid_q[pick][idx] && dirty_q[pick][idx]))
      |=> !mem_we); // R7

  AST_FILL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && cpu_req) |=> (cpu_ready || !cpu_req)); // R8

  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready); // R8
endmodule

// File: tb/sa2_cache_tb.sv
module sa2_cache_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         cpu_req = 0, cpu_we = 0;
  logic [11:0]  cpu_addr = 0;
  logic [31:0]  cpu_wdata = 0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready, mem_req, mem_we;
  logic [7:0]   mem_line_addr;
  logic [127:0] mem_wline;
  logic [127:0] mem_rline = 0;
  logic         mem_ack = 0;

  int checks = 0, fails = 0;
  logic [31:0] bmem [1024];
  logic [31:0] gold [1024];
  logic        any_req, wb_seen;
  logic [7:0]  wb_addr;
  logic        mv [2][8], md [2][8], ml [8];
  logic [4:0]  mt [2][8];

  always #5 clk = ~clk;

  sa2_cache u_dut (.clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_line_addr(mem_line_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
    .mem_ack(mem_ack));

  function automatic logic [31:0] init_word(int a);
    return 32'hA500_0000 ^ (a * 32'h0000_9E37);
  endfunction

  function automatic logic [11:0] mk(int t, int s, int w, int b);
    return {t[4:0], s[2:0], w[1:0], b[1:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int dly;
    dly = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; dly = 0;
      end else if (mem_req) begin
        any_req = 1; dly++;
        if (dly == 3) begin
          if (mem_we) begin
            wb_seen = 1; wb_addr = mem_line_addr;
            for (int w = 0; w < 4; w++) bmem[{mem_line_addr, w[1:0]}] = mem_wline[w*32 +: 32];
          end else begin
            for (int w = 0; w < 4; w++) mem_rline[w*32 +: 32] = bmem[{mem_line_addr, w[1:0]}];
          end
          mem_ack = 1;
        end
      end
    end
  end

  task automatic access(input logic [11:0] a, input bit we, input logic [31:0] wd);
    logic [4:0] t; logic [2:0] s; logic [9:0] wa;
    bit ehit, ewb, way; logic [7:0] ewb_addr; int cnt;
    t = a[11:7]; s = a[6:4]; wa = a[11:2];
    ehit = 0; way = 0;
    for (int w = 0; w < 2; w++) if (mv[w][s] && mt[w][s] == t) begin ehit = 1; way = w[0]; end
    if (!ehit) way = !mv[0][s] ? 1'b0 : !mv[1][s] ? 1'b1 : ml[s];
    ewb = !ehit && mv[way][s] && md[way][s];
    ewb_addr = {mt[way][s], s};
    @(negedge clk); #1;
    any_req = 0; wb_seen = 0;
    cpu_addr = a; cpu_we = we; cpu_wdata = wd; cpu_req = 1;
    #1; cnt = 0;
    while (!cpu_ready && cnt < 200) begin @(negedge clk); #1; cnt++; end
    chk(cnt < 200, "R8 ready timeout", cnt, 0);
    if (ehit) begin
      chk(cnt == 0, "R2 R4 hit latency", cnt, 0);
      chk(!any_req, "R2 no memory transfer on hit", any_req, 0);
    end else begin
      chk(cnt > 0, "R3 R4 R8 miss stall", cnt, 1);
      chk(wb_seen == ewb, "R6 R7 write-back presence", wb_seen, ewb);
      if (ewb) chk(wb_addr == ewb_addr, "R6 write-back line address", wb_addr, ewb_addr);
    end
    if (!we) chk(cpu_rdata == gold[wa], "R1 R5 R8 read data", cpu_rdata, gold[wa]);
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
    if (!ehit) begin mv[way][s] = 1; mt[way][s] = t; md[way][s] = 0; end
    ml[s] = ~way;
    if (we) begin md[way][s] = 1; gold[wa] = wd; end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < 1024; i++) begin bmem[i] = init_word(i); gold[i] = init_word(i); end
    for (int s = 0; s < 8; s++) begin ml[s] = 0; for (int w = 0; w < 2; w++) begin mv[w][s] = 0; md[w][s] = 0; mt[w][s] = 0; end end
    any_req = 0; wb_seen = 0; wb_addr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!cpu_ready && !mem_req, "R9 reset outputs", {cpu_ready, mem_req}, 0);
    @(negedge clk); rst_n = 1;

    access(mk(1,2,1,0), 0, 0);       // R9 R3 cold miss, way 0
    access(mk(1,2,1,3), 0, 0);       // R1 R2 offset bits ignored, hit
    access(mk(2,2,0,0), 0, 0);       // R3 second way fill
    access(mk(1,2,3,0), 0, 0);       // R4 touch tag 1
    access(mk(3,2,0,0), 0, 0);       // R4 evicts tag 2
    access(mk(1,2,2,0), 0, 0);       // R4 tag 1 still resident
    access(mk(1,2,2,0), 1, 32'hDEAD_BEEF); // R5 write hit
    access(mk(1,2,2,0), 0, 0);       // R5 read back
    access(mk(3,2,1,0), 0, 0);       // R4 touch tag 3
    access(mk(4,2,0,0), 0, 0);       // R6 dirty eviction of tag 1
    access(mk(1,2,2,0), 0, 0);       // R6 written-back data returns
    access(mk(5,3,0,0), 1, 32'h1234_5678); // R8 write miss then hit
    access(mk(5,3,0,0), 0, 0);       // R8 R5
    access(mk(6,3,0,0), 0, 0);       // R7 clean fill of way 1

    seed = $urandom(32'h00C0FFEE);
    for (int n = 0; n < 800; n++) begin
      int t, s, w;
      t = $urandom_range(0, 3); s = $urandom_range(0, 7); w = $urandom_range(0, 3);
      access(mk(t, s, w, $urandom_range(0, 3)), $urandom_range(0, 2) == 0, $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule